// File: doc/BRIEF.md
# Set-Associative Address Translation Buffer with Process Tags

This block caches virtual-to-physical page translations for a 32-bit address space with 4 KiB pages. Entries live in an array of `SETS = ENTRIES / WAYS` sets, each set holding `WAYS` entries. A lookup presents a virtual address and the current process tag. The set is picked from the low bits of the virtual page number. Every way of that set is compared in parallel, and the matching entry's frame number and permission bits come back one clock later.

Each entry has a tag part and a data part. The tag part is a valid flag, the 20-bit virtual page number, a process tag of `PID_W` bits and a global flag. The data part is a 20-bit physical frame number and four permission bits. Software loads an entry by naming the set and the way directly. The block makes no replacement choice of its own. A global entry matches any process tag. Software must never leave two valid entries in one set that can match the same page and tag: the result of a double match is undefined.

Top module: `tlb_xlate`

## Requirements
- R1: After reset every entry is invalid and `rsp_valid`, `rsp_hit`, `rsp_paddr` and `rsp_perm` are 0, so any lookup made before the first write misses.
- R2: A lookup hits only when a valid entry in the selected set holds a page number equal to `lk_vaddr[31:12]`. A page number that differs in any bit misses.
- R3: For an entry whose global flag is 0, a hit also needs the stored process tag to equal `lk_pid`.
- R4: For an entry whose global flag is 1, `lk_pid` is ignored and the match depends on the page number alone.
- R5: The set compared is `lk_vaddr[12+IDX_W-1:12]`, with `IDX_W = log2(ENTRIES/WAYS)`. An entry loaded into any other set never hits, even when its page number matches.
- R6: A write with `wr_en = 1` replaces exactly the entry at (`wr_set`, `wr_way`). Entries in other ways of the same set keep their contents.
- R7: On a hit, `rsp_paddr = {frame, lk_vaddr[11:0]}` and `rsp_perm` holds the stored permissions: bit 0 read, bit 1 write, bit 2 execute, bit 3 cacheable. On a miss, both outputs are 0.
- R8: Each lookup produces its response on the clock edge after the one that samples it: `rsp_valid` is `lk_valid` delayed by one cycle.
- R9: A write in the same cycle as a lookup to the same set is not seen by that lookup. It is seen by later lookups.
- R10: An entry written with `wr_valid = 0` never hits.
- R11: `rsp_hit` is 0 whenever `rsp_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_valid | input | 1 | Lookup request strobe |
| lk_vaddr | input | 32 | Virtual address to translate |
| lk_pid | input | PID_W | Current process tag |
| wr_en | input | 1 | Entry write strobe |
| wr_set | input | IDX_W | Set receiving the entry |
| wr_way | input | WAY_W | Way receiving the entry |
| wr_valid | input | 1 | Valid flag of the new entry |
| wr_vpn | input | 20 | Virtual page number of the new entry |
| wr_pid | input | PID_W | Process tag of the new entry |
| wr_global | input | 1 | Global flag of the new entry |
| wr_pfn | input | 20 | Physical frame number of the new entry |
| wr_perm | input | 4 | Permissions: bit 0 read, bit 1 write, bit 2 execute, bit 3 cacheable |
| rsp_valid | output | 1 | Response strobe, one cycle after `lk_valid` |
| rsp_hit | output | 1 | Lookup matched an entry |
| rsp_paddr | output | 32 | Translated physical address, 0 on a miss |
| rsp_perm | output | 4 | Permissions of the matched entry, 0 on a miss |

## Verification
Every response is due exactly one clock after its request. The bench drives inputs on the falling edge, and its model computes the expected response at the rising edge, from the entry contents held before that edge's write. The model then applies the write, so a write takes effect from the cycle after it is driven. All four response outputs are compared with the model on the following falling edge, in every cycle. The directed tasks check each response one full cycle after they drive the request. The same-cycle write case is checked both on that response and on the next lookup.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
   localparam int VA_W     = 32;
   localparam int PG_OFF_W = 12;
   localparam int VPN_W    = VA_W - PG_OFF_W;
   localparam int PFN_W    = 20;
   localparam int PERM_W   = 4;

   localparam int PERM_RD  = 0;
   localparam int PERM_WR  = 1;
   localparam int PERM_EX  = 2;
   localparam int PERM_CA  = 3;

   typedef logic [VPN_W-1:0]  vpn_t;
   typedef logic [PFN_W-1:0]  pfn_t;
   typedef logic [PERM_W-1:0] perm_t;

   typedef struct packed {
      logic  vld;
      logic  glb;
      vpn_t  vpn;
      pfn_t  pfn;
      perm_t perm;
   } slot_t;
endpackage

// File: rtl/tlb_way_bank.sv
module tlb_way_bank
   import tlb_pkg::*;
#(
   parameter int SETS  = 16,
   parameter int IDX_W = 4,
   parameter int PID_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we,
   input  logic [IDX_W-1:0] w_idx,
   input  slot_t            w_slot,
   input  logic [PID_W-1:0] w_pid,
   input  logic [IDX_W-1:0] r_idx,
   output slot_t            r_slot,
   output logic [PID_W-1:0] r_pid
);
   logic [SETS-1:0]  vld_q;
   logic             glb_q  [SETS];
   vpn_t             vpn_q  [SETS];
   pfn_t             pfn_q  [SETS];
   perm_t            perm_q [SETS];
   logic [PID_W-1:0] pid_q  [SETS];

   initial begin
      assert (SETS == (1 << IDX_W)) else $error("tlb_way_bank: SETS must equal 2**IDX_W");
   end

   // Only the valid flags need a reset; the payload is ignored while invalid.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vld_q <= '0;
      end else if (we) begin
         vld_q[w_idx] <= w_slot.vld;
      end
   end

   always_ff @(posedge clk) begin
      if (we) begin
         glb_q[w_idx]  <= w_slot.glb;
         vpn_q[w_idx]  <= w_slot.vpn;
         pfn_q[w_idx]  <= w_slot.pfn;
         perm_q[w_idx] <= w_slot.perm;
         pid_q[w_idx]  <= w_pid;
      end
   end

   // The read is combinational from the current state, so a write in the
   // same cycle is seen only by later lookups.
   always_comb begin
      r_slot.vld  = vld_q[r_idx];
      r_slot.glb  = glb_q[r_idx];
      r_slot.vpn  = vpn_q[r_idx];
      r_slot.pfn  = pfn_q[r_idx];
      r_slot.perm = perm_q[r_idx];
      r_pid       = pid_q[r_idx];
   end

   // R10: an entry written invalid reads back invalid afterwards
   a_r10_invalid_write_clears : assert property (@(posedge clk) disable iff (!rst_n)
      (we && !w_slot.vld) |=> !vld_q[$past(w_idx)]);
endmodule

// File: rtl/tlb_way_match.sv
module tlb_way_match
   import tlb_pkg::*;
#(
   parameter int PID_W = 8
) (
   input  slot_t            slot,
   input  logic [PID_W-1:0] slot_pid,
   input  vpn_t             q_vpn,
   input  logic [PID_W-1:0] q_pid,
   output logic             hit
);
   logic page_eq;
   logic tag_ok;

   always_comb begin
      page_eq = (slot.vpn == q_vpn);
      tag_ok  = slot.glb || (slot_pid == q_pid);
      hit     = slot.vld && page_eq && tag_ok;
   end
endmodule

// File: rtl/tlb_hit_sel.sv
module tlb_hit_sel
   import tlb_pkg::*;
#(
   parameter int WAYS = 16
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [WAYS-1:0] hit_vec,
   input  pfn_t            pfn_in  [WAYS],
   input  perm_t           perm_in [WAYS],
   output logic            any_hit,
   output pfn_t            pfn_out,
   output perm_t           perm_out
);
   // AND-OR select: correct for at most one hot way, which software guarantees.
   always_comb begin
      pfn_out  = '0;
      perm_out = '0;
      for (int w = 0; w < WAYS; w++) begin
         pfn_out  = pfn_out  | (pfn_in[w]  & {PFN_W{hit_vec[w]}});
         perm_out = perm_out | (perm_in[w] & {PERM_W{hit_vec[w]}});
      end
      any_hit = |hit_vec;
   end

   // R2: with distinct mappings at most one way of a set matches
   a_r2_single_way_match : assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(hit_vec));
endmodule

// File: rtl/tlb_xlate.sv
module tlb_xlate
   import tlb_pkg::*;
#(
   parameter int WAYS    = 16,
   parameter int ENTRIES = 256,
   parameter int PID_W   = 8,
   localparam int SETS   = ENTRIES / WAYS,
   localparam int IDX_W  = (SETS > 1) ? $clog2(SETS) : 1,
   localparam int WAY_W  = (WAYS > 1) ? $clog2(WAYS) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             lk_valid,
   input  logic [31:0]      lk_vaddr,
   input  logic [PID_W-1:0] lk_pid,
   input  logic             wr_en,
   input  logic [IDX_W-1:0] wr_set,
   input  logic [WAY_W-1:0] wr_way,
   input  logic             wr_valid,
   input  logic [19:0]      wr_vpn,
   input  logic [PID_W-1:0] wr_pid,
   input  logic             wr_global,
   input  logic [19:0]      wr_pfn,
   input  logic [3:0]       wr_perm,
   output logic             rsp_valid,
   output logic             rsp_hit,
   output logic [31:0]      rsp_paddr,
   output logic [3:0]       rsp_perm
);
   initial begin
      assert (PID_W >= 8 && PID_W <= 14) else $error("tlb_xlate: PID_W must lie in 8..14");
      assert (ENTRIES == 128 || ENTRIES == 256) else $error("tlb_xlate: ENTRIES must be 128 or 256");
      assert (WAYS >= 2 && (WAYS & (WAYS - 1)) == 0) else $error("tlb_xlate: WAYS must be a power of two >= 2");
      assert (SETS >= 2 && SETS * WAYS == ENTRIES) else $error("tlb_xlate: ENTRIES must be a multiple of WAYS giving >= 2 sets");
   end

   vpn_t             q_vpn;
   logic [IDX_W-1:0] q_idx;
   slot_t            w_slot;
   slot_t            rd_slot [WAYS];
   logic [PID_W-1:0] rd_pid  [WAYS];
   pfn_t             rd_pfn  [WAYS];
   perm_t            rd_perm [WAYS];
   logic [WAYS-1:0]  hit_vec;
   logic             any_hit;
   pfn_t             sel_pfn;
   perm_t            sel_perm;

   always_comb begin
      q_vpn       = lk_vaddr[VA_W-1:PG_OFF_W];
      q_idx       = q_vpn[IDX_W-1:0];
      w_slot.vld  = wr_valid;
      w_slot.glb  = wr_global;
      w_slot.vpn  = wr_vpn;
      w_slot.pfn  = wr_pfn;
      w_slot.perm = wr_perm;
   end

   for (genvar w = 0; w < WAYS; w++) begin : g_way
      logic way_we;
      assign way_we = wr_en && (wr_way == WAY_W'(w));

      tlb_way_bank #(.SETS(SETS), .IDX_W(IDX_W), .PID_W(PID_W)) u_bank (
         .clk    (clk),
         .rst_n  (rst_n),
         .we     (way_we),
         .w_idx  (wr_set),
         .w_slot (w_slot),
         .w_pid  (wr_pid),
         .r_idx  (q_idx),
         .r_slot (rd_slot[w]),
         .r_pid  (rd_pid[w])
      );

      tlb_way_match #(.PID_W(PID_W)) u_match (
         .slot     (rd_slot[w]),
         .slot_pid (rd_pid[w]),
         .q_vpn    (q_vpn),
         .q_pid    (lk_pid),
         .hit      (hit_vec[w])
      );

      assign rd_pfn[w]  = rd_slot[w].pfn;
      assign rd_perm[w] = rd_slot[w].perm;
   end

   tlb_hit_sel #(.WAYS(WAYS)) u_sel (
      .clk      (clk),
      .rst_n    (rst_n),
      .hit_vec  (hit_vec),
      .pfn_in   (rd_pfn),
      .perm_in  (rd_perm),
      .any_hit  (any_hit),
      .pfn_out  (sel_pfn),
      .perm_out (sel_perm)
   );

   logic take;
   assign take = lk_valid && any_hit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_hit   <= 1'b0;
         rsp_paddr <= '0;
         rsp_perm  <= '0;
      end else begin
         rsp_valid <= lk_valid;
         rsp_hit   <= take;
         rsp_paddr <= take ? {sel_pfn, lk_vaddr[PG_OFF_W-1:0]} : '0;
         rsp_perm  <= take ? sel_perm : '0;
      end
   end

   // R8: a response follows every request by one cycle
   a_r8_rsp_follows_req : assert property (@(posedge clk) disable iff (!rst_n)
      lk_valid |=> rsp_valid);
   // R8: no response without a request
   a_r8_no_spurious_rsp : assert property (@(posedge clk) disable iff (!rst_n)
      !lk_valid |=> !rsp_valid);
   // R11: hit only qualifies a valid response
   a_r11_hit_needs_rsp : assert property (@(posedge clk) disable iff (!rst_n)
      !rsp_valid |-> !rsp_hit);
   // R7: a miss drives zero address and permissions
   a_r7_miss_is_zero : assert property (@(posedge clk) disable iff (!rst_n)
      !rsp_hit |-> (rsp_paddr == '0 && rsp_perm == '0));
   // R7: the page offset passes straight through on a hit
   a_r7_offset_kept : assert property (@(posedge clk) disable iff (!rst_n)
      lk_valid |=> (!rsp_hit || rsp_paddr[11:0] == $past(lk_vaddr[11:0])));
endmodule

// File: tb/tlb_xlate_test.sv
`timescale 1ns/1ps
module tlb_xlate_test;
   localparam int WAYS    = 16;
   localparam int ENTRIES = 256;
   localparam int PID_W   = 8;
   localparam int SETS    = ENTRIES / WAYS;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             lk_valid = 1'b0;
   logic [31:0]      lk_vaddr = '0;
   logic [PID_W-1:0] lk_pid = '0;
   logic             wr_en = 1'b0;
   logic [3:0]       wr_set = '0;
   logic [3:0]       wr_way = '0;
   logic             wr_valid = 1'b0;
   logic [19:0]      wr_vpn = '0;
   logic [PID_W-1:0] wr_pid = '0;
   logic             wr_global = 1'b0;
   logic [19:0]      wr_pfn = '0;
   logic [3:0]       wr_perm = '0;
   logic             rsp_valid;
   logic             rsp_hit;
   logic [31:0]      rsp_paddr;
   logic [3:0]       rsp_perm;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 0;

   always #2 clk = ~clk;

   tlb_xlate #(.WAYS(WAYS), .ENTRIES(ENTRIES), .PID_W(PID_W)) uut (
      .clk(clk), .rst_n(rst_n),
      .lk_valid(lk_valid), .lk_vaddr(lk_vaddr), .lk_pid(lk_pid),
      .wr_en(wr_en), .wr_set(wr_set), .wr_way(wr_way), .wr_valid(wr_valid),
      .wr_vpn(wr_vpn), .wr_pid(wr_pid), .wr_global(wr_global),
      .wr_pfn(wr_pfn), .wr_perm(wr_perm),
      .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_paddr(rsp_paddr), .rsp_perm(rsp_perm)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
      end
   endtask

   // ---------------- behavioural reference model ----------------
   bit          m_vld  [SETS][WAYS];
   bit [19:0]   m_vpn  [SETS][WAYS];
   bit [7:0]    m_pid  [SETS][WAYS];
   bit          m_glb  [SETS][WAYS];
   bit [19:0]   m_pfn  [SETS][WAYS];
   bit [3:0]    m_perm [SETS][WAYS];
   bit          e_valid, e_hit;
   bit [31:0]   e_pa;
   bit [3:0]    e_perm;
   int          ms;
   bit          mh;
   bit [31:0]   mpa;
   bit [3:0]    mpm;

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int s = 0; s < SETS; s++)
            for (int w = 0; w < WAYS; w++) m_vld[s][w] = 0;
         e_valid = 0; e_hit = 0; e_pa = 0; e_perm = 0;
      end else begin
         ms = int'(lk_vaddr[15:12]);
         mh = 0; mpa = 0; mpm = 0;
         for (int w = 0; w < WAYS; w++) begin
            if (m_vld[ms][w] && m_vpn[ms][w] == lk_vaddr[31:12] &&
                (m_glb[ms][w] || m_pid[ms][w] == lk_pid)) begin
               mh = 1; mpa = {m_pfn[ms][w], lk_vaddr[11:0]}; mpm = m_perm[ms][w];
            end
         end
         e_valid = lk_valid;
         e_hit   = lk_valid && mh;
         e_pa    = e_hit ? mpa : 32'h0;
         e_perm  = e_hit ? mpm : 4'h0;
         if (wr_en) begin
            m_vld[wr_set][wr_way]  = wr_valid;
            m_vpn[wr_set][wr_way]  = wr_vpn;
            m_pid[wr_set][wr_way]  = wr_pid;
            m_glb[wr_set][wr_way]  = wr_global;
            m_pfn[wr_set][wr_way]  = wr_pfn;
            m_perm[wr_set][wr_way] = wr_perm;
         end
      end
   end

   always @(negedge clk) begin
      if (rst_n && !done) begin
         chk("R8 model rsp_valid", {31'h0, rsp_valid}, {31'h0, e_valid});
         chk("R2 model rsp_hit",   {31'h0, rsp_hit},   {31'h0, e_hit});
         chk("R7 model rsp_paddr", rsp_paddr,          e_pa);
         chk("R7 model rsp_perm",  {28'h0, rsp_perm},  {28'h0, e_perm});
      end
   end

   // ---------------- directed stimulus helpers ----------------
   task automatic put(input logic [3:0] s, input logic [3:0] w, input logic [19:0] vpn,
                      input logic [7:0] pid, input logic glb, input logic v,
                      input logic [19:0] pfn, input logic [3:0] perm);
      @(negedge clk);
      wr_en = 1; wr_set = s; wr_way = w; wr_vpn = vpn; wr_pid = pid;
      wr_global = glb; wr_valid = v; wr_pfn = pfn; wr_perm = perm;
      @(negedge clk);
      wr_en = 0;
   endtask

   task automatic look(input logic [31:0] va, input logic [7:0] pid, input string tag,
                       input logic ehit, input logic [31:0] epa, input logic [3:0] eperm);
      @(negedge clk);
      lk_valid = 1; lk_vaddr = va; lk_pid = pid;
      @(negedge clk);
      lk_valid = 0;
      chk({tag, " valid"}, {31'h0, rsp_valid}, 32'h1);
      chk({tag, " hit"},   {31'h0, rsp_hit},   {31'h0, ehit});
      chk({tag, " paddr"}, rsp_paddr, ehit ? epa : 32'h0);
      chk({tag, " perm"},  {28'h0, rsp_perm}, {28'h0, (ehit ? eperm : 4'h0)});
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      // R1: reset state
      chk("R1 reset rsp_valid", {31'h0, rsp_valid}, 32'h0);
      chk("R1 reset rsp_hit",   {31'h0, rsp_hit},   32'h0);
      chk("R1 reset rsp_paddr", rsp_paddr,          32'h0);
      look(32'h0000_1234, 8'h00, "R1 empty lookup", 0, 0, 0);

      put(4'd1, 4'd3, 20'h12341, 8'h5A, 0, 1, 20'hABCDE, 4'b0101);
      look(32'h1234_1678, 8'h5A, "R2 R7 hit", 1, 32'hABCD_E678, 4'b0101);
      look(32'h1234_1678, 8'h5B, "R3 tag mismatch", 0, 0, 0);
      look(32'h2234_1678, 8'h5A, "R2 page mismatch", 0, 0, 0);

      put(4'd2, 4'd0, 20'h00072, 8'h11, 1, 1, 20'h0F00F, 4'b1111);
      look(32'h0007_2ABC, 8'hEE, "R4 global hit", 1, 32'h0F00_FABC, 4'b1111);

      put(4'd4, 4'd1, 20'h00033, 8'h22, 0, 1, 20'h77777, 4'b0001);
      look(32'h0003_3000, 8'h22, "R5 wrong set", 0, 0, 0);

      put(4'd1, 4'd3, 20'h12341, 8'h5A, 0, 1, 20'h11111, 4'b0010);
      put(4'd1, 4'd7, 20'h45671, 8'h5A, 0, 1, 20'h22222, 4'b1000);
      look(32'h1234_1004, 8'h5A, "R6 overwrite", 1, 32'h1111_1004, 4'b0010);
      look(32'h4567_1FFF, 8'h5A, "R6 other way", 1, 32'h2222_2FFF, 4'b1000);

      put(4'd1, 4'd7, 20'h45671, 8'h5A, 0, 0, 20'h22222, 4'b1000);
      look(32'h4567_1FFF, 8'h5A, "R10 invalid entry", 0, 0, 0);
      look(32'h1234_1004, 8'h5A, "R6 neighbour kept", 1, 32'h1111_1004, 4'b0010);

      // R9: write and lookup to the same set in one cycle
      @(negedge clk);
      lk_valid = 1; lk_vaddr = 32'h9999_1000; lk_pid = 8'h01;
      wr_en = 1; wr_set = 4'd1; wr_way = 4'd9; wr_vpn = 20'h99991; wr_pid = 8'h01;
      wr_global = 0; wr_valid = 1; wr_pfn = 20'h33333; wr_perm = 4'b0110;
      @(negedge clk);
      lk_valid = 0; wr_en = 0;
      chk("R9 same-cycle miss", {31'h0, rsp_hit}, 32'h0);
      look(32'h9999_1ABC, 8'h01, "R9 later hit", 1, 32'h3333_3ABC, 4'b0110);

      // R11: idle cycle after a hit
      @(negedge clk);
      chk("R11 idle valid", {31'h0, rsp_valid}, 32'h0);
      chk("R11 idle hit",   {31'h0, rsp_hit},   32'h0);

      // random phase: one fixed slot per page keeps mappings distinct
      for (int i = 0; i < 3000; i++) begin
         logic [8:0] lv, wv;
         @(negedge clk);
         lv = 9'($urandom_range(0, 511));
         wv = 9'($urandom_range(0, 511));
         lk_valid  = ($urandom % 2) == 0;
         lk_vaddr  = {11'h400, lv, 12'($urandom)};
         lk_pid    = 8'($urandom_range(1, 2));
         wr_en     = ($urandom % 3) == 0;
         wr_set    = wv[3:0];
         wr_way    = wv[7:4];
         wr_vpn    = {11'h400, wv};
         wr_pid    = 8'($urandom_range(1, 2));
         wr_global = ($urandom % 4) == 0;
         wr_valid  = ($urandom % 8) != 0;
         wr_pfn    = 20'($urandom);
         wr_perm   = 4'($urandom);
      end
      @(negedge clk);
      lk_valid = 0; wr_en = 0;
      @(negedge clk);
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      #(4 * 200000);
      if (!done) begin
         done = 1;
         n_chk++;
         n_bad++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end
endmodule